// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs next to a simple processor's fetch-execute loop and handles the hardware side of taking an interrupt and returning from it. It holds the architectural program counter, the status word, and two stack pointers: one for user code and one for the kernel. The processor reports each completed ordinary instruction with a step strobe, and each decoded return-from-interrupt instruction with a return strobe. The processor drives neither strobe while the fetch stall is high.

On a step, the block moves the program counter forward by one 4-byte instruction and records the condition codes. If an interrupt request is present at that boundary and the enable bit is set, the block stalls fetch. It then writes the interrupted status word and the return address onto the kernel stack. Next it reads the handler address and the handler's own status word from a two-word vector entry. In a single final cycle it loads the program counter, the status word and the kernel stack pointer together. The return strobe reverses this: it reads both saved words back and restores them in one step. A return strobe in user mode is refused and signals a privilege fault.

Memory is a single synchronous port: read data appears on the cycle after the request. Addresses are byte addresses, and each word is 4 bytes.

Top module: `irq_seq`

## Requirements
- R1: After reset: the PC is 0xA000, the status word is 0x10 (user mode, interrupts enabled, condition codes clear), the active SP is 0xFFF0, the kernel SP is 3000, and stall and fault are low.
- R2: A step while idle moves the PC forward by 4 and copies `cc_in` into the status word. The status word bits are: bit0 carry, bit1 overflow, bit2 divide-by-zero, bit3 mode (1 = kernel), bit4 interrupt enable.
- R3: A step taken with `irq_req` high and bit4 set starts an entry. The block first writes the status word, zero-extended and including the new condition codes, to kernel SP − 4. It then writes the advanced PC to kernel SP − 8.
- R4: With bit4 clear, a step never starts an entry, whatever the state of `irq_req`. No memory write takes place.
- R5: The entry reads the handler PC from byte address `irq_vec` and the handler status word from `irq_vec` + 4. It loads both in one cycle and lowers the kernel SP by 8.
- R6: The `sp` output shows the kernel SP while bit3 is 1, and the user SP while bit3 is 0.
- R7: A return strobe in kernel mode reads the PC from the kernel SP and the status word from kernel SP + 4. It restores both in one cycle and raises the kernel SP by 8.
- R8: A return strobe in user mode gives a one-cycle `fault` pulse on the following cycle. It makes no memory access and leaves the PC, status word and SP unchanged.
- R9: Stall rises on the cycle after the strobe. It lasts 5 cycles for an entry and 3 cycles for a return. Memory is accessed only while stall is high.
- R10: `irq_req` is sampled only together with a step. A request held while no step is given causes no stall and no change to the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Ordinary instruction completed (instruction boundary) |
| iret | input | 1 | Decoded return-from-interrupt instruction |
| cc_in | input | 3 | Condition codes of the completed instruction |
| irq_req | input | 1 | Interrupt request pending |
| irq_vec | input | ADDR_W | Byte address of the vector entry for the request |
| stall | output | 1 | Fetch stall while a sequence runs |
| fault | output | 1 | Privilege fault pulse for a user-mode return |
| pc | output | ADDR_W | Architectural program counter |
| psw | output | 5 | Status word |
| sp | output | ADDR_W | Active stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after a read request |

## Verification
A corrupted sequencer state shows up directly at the memory port. Writes go to the wrong kernel stack slot or carry the wrong value, and the scoreboard rejects them in the very cycle they are issued. A wrong stall length, or a context loaded from the wrong word, shows up in `pc`, `psw` and `sp` as soon as stall falls. A kernel SP that is off is hidden until the next entry or return, where it moves the push or pop addresses. For this reason the bench chains two entries and two returns.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WORD_BYTES = 4;
    localparam int CC_W       = 3;

    typedef struct packed {
        logic ie;
        logic kmode;
        logic dz;
        logic ov;
        logic cy;
    } psw_t;

    localparam int PSW_W = $bits(psw_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSW,
        ST_PUSH_PC,
        ST_RD_VPC,
        ST_RD_VPSW,
        ST_DONE,
        ST_POP_PC,
        ST_POP_PSW
    } seq_st_e;

    function automatic psw_t psw_with_cc(input psw_t p, input logic [CC_W-1:0] cc);
        psw_t r;
        r    = p;
        r.cy = cc[0];
        r.ov = cc[1];
        r.dz = cc[2];
        return r;
    endfunction

endpackage

// File: rtl/irq_seq_state.sv
module irq_seq_state
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int RESET_PC = 'hA000,
    parameter int USP_INIT = 'hFFF0,
    parameter int KSP_TOP  = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [CC_W-1:0]   cc_in,
    input  logic              ld_ctx,
    input  logic              ctx_enter,
    input  logic [ADDR_W-1:0] ctx_pc,
    input  psw_t              ctx_psw,
    output logic [ADDR_W-1:0] pc,
    output psw_t              psw,
    output logic [ADDR_W-1:0] ksp,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] FRAME_A = ADDR_W'(2 * WORD_BYTES);

    logic [ADDR_W-1:0] usp;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= ADDR_W'(RESET_PC);
            psw <= '{ie: 1'b1, kmode: 1'b0, dz: 1'b0, ov: 1'b0, cy: 1'b0};
            usp <= ADDR_W'(USP_INIT);
            ksp <= ADDR_W'(KSP_TOP);
        end else if (ld_ctx) begin
            pc  <= ctx_pc;
            psw <= ctx_psw;
            ksp <= ctx_enter ? ksp - FRAME_A : ksp + FRAME_A;
        end else if (adv) begin
            pc  <= pc + STEP_A;
            psw <= psw_with_cc(psw, cc_in);
        end
    end

    assign sp = psw.kmode ? ksp : usp;

endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              iret,
    input  logic              irq_req,
    input  logic [ADDR_W-1:0] irq_vec,
    input  logic [ADDR_W-1:0] pc,
    input  psw_t              psw,
    input  logic [ADDR_W-1:0] ksp,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              stall,
    output logic              fault,
    output logic              adv,
    output logic              ld_ctx,
    output logic              ctx_enter,
    output logic [ADDR_W-1:0] ctx_pc,
    output psw_t              ctx_psw,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] FRAME_A = ADDR_W'(2 * WORD_BYTES);

    seq_st_e           state;
    logic [ADDR_W-1:0] vec_q;
    logic [ADDR_W-1:0] tmp_pc;
    logic              enter_q;
    logic              fault_q;
    logic              idle;
    logic              take_irq;
    logic              take_ret;
    logic              unused_rdata_hi;

    assign unused_rdata_hi = ^mem_rdata[DATA_W-1:ADDR_W];

    assign idle     = (state == ST_IDLE);
    assign adv      = idle && step && !iret;
    assign take_irq = adv && irq_req && psw.ie;
    assign take_ret = idle && iret && psw.kmode;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            vec_q   <= '0;
            tmp_pc  <= '0;
            enter_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= idle && iret && !psw.kmode;
            unique case (state)
                ST_IDLE: begin
                    if (take_ret) begin
                        state   <= ST_POP_PC;
                        enter_q <= 1'b0;
                    end else if (take_irq) begin
                        state   <= ST_PUSH_PSW;
                        enter_q <= 1'b1;
                        vec_q   <= irq_vec;
                    end
                end
                ST_PUSH_PSW: state <= ST_PUSH_PC;
                ST_PUSH_PC:  state <= ST_RD_VPC;
                ST_RD_VPC:   state <= ST_RD_VPSW;
                ST_RD_VPSW: begin
                    tmp_pc <= mem_rdata[ADDR_W-1:0];
                    state  <= ST_DONE;
                end
                ST_POP_PC:   state <= ST_POP_PSW;
                ST_POP_PSW: begin
                    tmp_pc <= mem_rdata[ADDR_W-1:0];
                    state  <= ST_DONE;
                end
                ST_DONE:     state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_PSW: begin
                mem_we    = 1'b1;
                mem_addr  = ksp - STEP_A;
                mem_wdata = DATA_W'(psw);
            end
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = ksp - FRAME_A;
                mem_wdata = DATA_W'(pc);
            end
            ST_RD_VPC:  mem_addr = vec_q;
            ST_RD_VPSW: mem_addr = vec_q + STEP_A;
            ST_POP_PC:  mem_addr = ksp;
            ST_POP_PSW: mem_addr = ksp + STEP_A;
            default:    mem_req  = 1'b0;
        endcase
    end

    assign stall     = !idle;
    assign fault     = fault_q;
    assign ld_ctx    = (state == ST_DONE);
    assign ctx_enter = enter_q;
    assign ctx_pc    = tmp_pc;
    assign ctx_psw   = psw_t'(mem_rdata[PSW_W-1:0]);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int RESET_PC = 'hA000,
    parameter int USP_INIT = 'hFFF0,
    parameter int KSP_TOP  = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              iret,
    input  logic [2:0]        cc_in,
    input  logic              irq_req,
    input  logic [ADDR_W-1:0] irq_vec,
    output logic              stall,
    output logic              fault,
    output logic [ADDR_W-1:0] pc,
    output logic [4:0]        psw,
    output logic [ADDR_W-1:0] sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    psw_t              psw_q;
    psw_t              ctx_psw;
    logic [ADDR_W-1:0] ksp;
    logic [ADDR_W-1:0] ctx_pc;
    logic              adv;
    logic              ld_ctx;
    logic              ctx_enter;

    irq_seq_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk(clk), .rst(rst), .step(step), .iret(iret),
        .irq_req(irq_req), .irq_vec(irq_vec),
        .pc(pc), .psw(psw_q), .ksp(ksp), .mem_rdata(mem_rdata),
        .stall(stall), .fault(fault), .adv(adv), .ld_ctx(ld_ctx),
        .ctx_enter(ctx_enter), .ctx_pc(ctx_pc), .ctx_psw(ctx_psw),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    irq_seq_state #(
        .ADDR_W(ADDR_W), .RESET_PC(RESET_PC),
        .USP_INIT(USP_INIT), .KSP_TOP(KSP_TOP)
    ) u_state (
        .clk(clk), .rst(rst), .adv(adv), .cc_in(cc_in),
        .ld_ctx(ld_ctx), .ctx_enter(ctx_enter), .ctx_pc(ctx_pc),
        .ctx_psw(ctx_psw), .pc(pc), .psw(psw_q), .ksp(ksp), .sp(sp)
    );

    assign psw = psw_q;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              step,
    input logic              iret,
    input logic              stall,
    input logic              fault,
    input logic              mem_req,
    input logic [ADDR_W-1:0] pc,
    input logic [4:0]        psw
);
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && step && !iret) |=> (pc == $past(pc) + ADDR_W'(4))); // R2

    AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!stall && step && !iret && !psw[4]) |=> !stall); // R4

    AST_USER_IRET_FAULT: assert property (@(posedge clk) disable iff (rst)
        (!stall && iret && !psw[3]) |=> (fault && !stall && $stable(pc) && $stable(psw))); // R8

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(!stall && iret && !psw[3])); // R8

    AST_MEM_ONLY_STALLED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> stall); // R9

    AST_KERNEL_IRET_STALLS: assert property (@(posedge clk) disable iff (rst)
        (!stall && iret && psw[3]) |=> stall); // R9

    AST_NO_SPONTANEOUS_STALL: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(step || iret)); // R10

endmodule

bind irq_seq irq_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .step(step), .iret(iret), .stall(stall),
    .fault(fault), .mem_req(mem_req), .pc(pc), .psw(psw)
);

// File: tb/tb_irq_seq.sv
module tb_irq_seq;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step = 1'b0;
    logic          iret = 1'b0;
    logic [2:0]    cc_in = '0;
    logic          irq_req = 1'b0;
    logic [AW-1:0] irq_vec = '0;
    logic          stall, fault, mem_req, mem_we;
    logic [AW-1:0] pc, sp, mem_addr;
    logic [4:0]    psw;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct { int addr; int data; } wr_item_t;
    wr_item_t exp_q[$];
    logic [DW-1:0] mem [int];

    always #10 clk = ~clk;

    irq_seq dut (
        .clk(clk), .rst(rst), .step(step), .iret(iret), .cc_in(cc_in),
        .irq_req(irq_req), .irq_vec(irq_vec), .stall(stall), .fault(fault),
        .pc(pc), .psw(psw), .sp(sp), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
        end
    end

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    // scoreboard monitor: every memory write must match the queue head (R3)
    always @(negedge clk) begin
        if (!rst && mem_req && mem_we) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected write addr", int'(mem_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check("R3 push addr", int'(mem_addr), it.addr);
                check("R3 push data", int'(mem_wdata), it.data);
            end
        end
    end

    task automatic expect_push(input int addr, input int data);
        wr_item_t it;
        it.addr = addr;
        it.data = data;
        exp_q.push_back(it);
    endtask

    task automatic strobe_step(input logic [2:0] cc);
        @(negedge clk);
        step  = 1'b1;
        cc_in = cc;
        @(negedge clk);
        step  = 1'b0;
    endtask

    task automatic strobe_iret();
        @(negedge clk);
        iret = 1'b1;
        @(negedge clk);
        iret = 1'b0;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (stall && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_ctx(input string req, input int epc, input int epsw, input int esp);
        check({req, " pc"}, int'(pc), epc);
        check({req, " psw"}, int'(psw), epsw);
        check({req, " sp"}, int'(sp), esp);
    endtask

    initial begin
        int n;
        mem[500] = 32'd100;
        mem[504] = 32'h08;
        mem[768] = 32'h200;
        mem[772] = 32'h18;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_ctx("R1", 'hA000, 'h10, 'hFFF0);
        check("R1 stall", int'(stall), 0);
        check("R1 fault", int'(fault), 0);

        // R10 request without a step is ignored
        irq_req = 1'b1;
        irq_vec = 16'd500;
        repeat (3) @(negedge clk);
        check("R10 stall", int'(stall), 0);
        check("R10 pc", int'(pc), 'hA000);

        // R3/R5/R6/R9 first entry, interrupted at A000
        expect_push(2996, 'h15);
        expect_push(2992, 'hA004);
        strobe_step(3'b101);
        count_stall(n);
        check("R9 entry stall cycles", n, 5);
        check_ctx("R5 R6 entry", 100, 'h08, 2992);

        // R4 masked: handler runs with enable clear
        strobe_step(3'b000);
        check("R4 stall", int'(stall), 0);
        check_ctx("R4", 104, 'h08, 2992);
        irq_req = 1'b0;

        // R7 return restores A004, user status, user stack
        strobe_iret();
        count_stall(n);
        check("R9 return stall cycles", n, 3);
        check_ctx("R7 R6 return", 'hA004, 'h15, 'hFFF0);

        // R2 ordinary step
        strobe_step(3'b010);
        check_ctx("R2", 'hA008, 'h12, 'hFFF0);

        // R8 user-mode return refused
        strobe_iret();
        check("R8 fault", int'(fault), 1);
        check("R8 stall", int'(stall), 0);
        check_ctx("R8", 'hA008, 'h12, 'hFFF0);
        @(negedge clk);
        check("R8 fault pulse width", int'(fault), 0);

        // second entry with another vector; kernel SP must be back at 3000
        irq_req = 1'b1;
        irq_vec = 16'd768;
        expect_push(2996, 'h12);
        expect_push(2992, 'hA00C);
        strobe_step(3'b010);
        irq_req = 1'b0;
        count_stall(n);
        check("R9 second entry stall", n, 5);
        check_ctx("R5 second entry", 'h200, 'h18, 2992);

        strobe_step(3'b000);
        check_ctx("R2 kernel step", 'h204, 'h18, 2992);

        strobe_iret();
        count_stall(n);
        check("R9 second return stall", n, 3);
        check_ctx("R7 second return", 'hA00C, 'h12, 'hFFF0);

        check("R3 pending pushes", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule